// File: doc/BRIEF.md
# Memory-to-Memory Multicycle Processor Core

This core executes a program held in one shared word-addressed memory that also holds all data. It has no register file. Each instruction names up to two memory words through two 14-bit address fields. The core reads those words through a single synchronous memory port and writes the result back to memory. The only architectural register is the program counter.

A controller walks every instruction through a short sequence of states. It fetches the instruction word, reads the first operand word, and optionally reads a second word and a pointer-chased word. It then evaluates the result and writes it back. Any state that an instruction has no use for is skipped. Arithmetic, logic, shift, compare, copy and jump-target addition are done in a separate combinational unit.

The memory is expected to return read data one clock after the address is presented. A write happens when the core raises its write enable for one cycle.

Top module: `mmc_core`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` is 0. After release, the first fetch is from address 0.
- R2: The instruction word is decoded as follows: opcode in bits 31..29, immediate flag in bit 28, field A in bits 27..14, field B in bits 13..0. A register-form ALU instruction leaves the word at address B unchanged.
- R3: For opcodes 0 (add), 1 (bitwise NAND), 3 (unsigned less-than, giving 1 or 0) and 7 (multiply, low 32 bits), the word at A becomes f(mem[A], mem[B]) when the flag is 0. When the flag is 1, it becomes f(mem[A], B), with B zero-extended.
- R4: For opcode 2, with shift amount s (mem[B] or B), the result is mem[A] shifted right logically by s when s < 32. Otherwise it is mem[A] shifted left by s-32, which gives 0 when s-32 >= 32.
- R5: Opcode 4 with flag 0 copies mem[B] into mem[A]. With flag 1, it writes the zero-extended B into mem[A].
- R6: Opcode 5 with flag 0 writes mem[mem[B]] into mem[A]. The pointer is truncated to 14 bits.
- R7: Opcode 5 with flag 1 writes mem[B] to the address held in mem[A], truncated to 14 bits. mem[A] itself is left unchanged.
- R8: Opcode 6 with flag 0 sets the PC to mem[A] (low 14 bits) when mem[B] is 0, and to PC+1 otherwise. It performs no memory write.
- R9: Opcode 6 with flag 1 sets the PC to (mem[A] + B) truncated to 14 bits. It performs no memory write.
- R10: Every non-branch instruction advances the PC by one, wrapping from 16383 to 0.
- R11: Each non-branch instruction makes exactly one single-cycle write. The cycle count from fetch to the next fetch is:
  - 4 for immediate ALU forms and immediate copy;
  - 5 for register forms, register copy and opcode 5 with flag 1;
  - 6 for opcode 5 with flag 0;
  - 4 for a conditional branch;
  - 3 for a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 14 | Word address for the read or write of this cycle |
| mem_we | output | 1 | Write strobe; writes mem_wdata at mem_addr |
| mem_wdata | output | 32 | Data to write |
| mem_rdata | input | 32 | Word at the address presented in the previous cycle |

## Verification
The assertions assume that `mem_rdata` always carries the word at the address driven one cycle earlier. They also assume that `rst_n` is released away from the active clock edge. Without these, the state sequence and the operand capture that the properties track would have no meaning. The bench models memory with exactly that one-cycle latency, and it returns 0 for words never written. It changes `rst_n` only on falling clock edges and loads memory only while the core is held in reset, so every program starts from a known image.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_SHF  = 3'd2,
    OP_LT   = 3'd3,
    OP_CPY  = 3'd4,
    OP_CPI  = 3'd5,
    OP_BR   = 3'd6,
    OP_MUL  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH     = 3'd0,
    ST_READ_A    = 3'd1,
    ST_READ_B    = 3'd2,
    ST_READ_IND  = 3'd3,
    ST_EXECUTE   = 3'd4,
    ST_WRITEBACK = 3'd5
  } state_e;

endpackage

// File: rtl/mmc_alu.sv
module mmc_alu
  import mmc_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] result
);

  localparam logic [DW-1:0] DW_V = DW[DW-1:0];

  logic [DW-1:0] left_amt;

  always_comb begin
    left_amt = opnd_b - DW_V;
    unique case (op)
      OP_ADD:  result = opnd_a + opnd_b;
      OP_NAND: result = ~(opnd_a & opnd_b);
      OP_SHF: begin
        if (opnd_b < DW_V)        result = opnd_a >> opnd_b;
        else if (left_amt < DW_V) result = opnd_a << left_amt;
        else                      result = '0;
      end
      OP_LT:   result = {{(DW-1){1'b0}}, (opnd_a < opnd_b)};
      OP_CPY:  result = opnd_b;
      OP_CPI:  result = opnd_b;
      OP_BR:   result = opnd_a + opnd_b;
      OP_MUL:  result = opnd_a * opnd_b;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/mmc_ctrl.sv
module mmc_ctrl
  import mmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    dec_op,
  input  logic   dec_imm,
  output state_e state
);

  state_e state_d;
  logic   need_b;
  logic   need_ind;

  assign need_b   = !dec_imm || (dec_op == OP_CPI);
  assign need_ind = (dec_op == OP_CPI) && !dec_imm;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_FETCH:     state_d = ST_READ_A;
      ST_READ_A:    state_d = need_b ? ST_READ_B : ST_EXECUTE;
      ST_READ_B:    state_d = need_ind ? ST_READ_IND : ST_EXECUTE;
      ST_READ_IND:  state_d = ST_EXECUTE;
      ST_EXECUTE:   state_d = (dec_op == OP_BR) ? ST_FETCH : ST_WRITEBACK;
      ST_WRITEBACK: state_d = ST_FETCH;
      default:      state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_d;
  end

  AST_FETCH_TO_READ_A: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FETCH) |=> (state == ST_READ_A)) else $error("fetch not followed by operand read"); // R11
  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_WRITEBACK) |=> (state == ST_FETCH)) else $error("writeback not followed by fetch"); // R11
  AST_IND_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_READ_IND) |-> ($past(state) == ST_READ_B)) else $error("pointer read without second operand read"); // R6

endmodule

// File: rtl/mmc_core.sv
module mmc_core
  import mmc_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int B_LSB   = 0;
  localparam int A_LSB   = AW;
  localparam int IMM_BIT = 2 * AW;
  localparam int OP_LSB  = 2 * AW + 1;
  localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

  generate
    if (DW != OP_LSB + OPW) begin : g_bad_width
      $error("instruction word width does not match field layout");
    end
  endgenerate

  state_e        state;
  logic [AW-1:0] pc, pc_d;
  logic          pc_en;
  logic [DW-1:0] ir;
  logic          ir_en;
  logic [DW-1:0] opa;
  logic          opa_en;
  logic          pend_is_a, pend_en;
  logic [DW-1:0] res;
  logic          res_en;
  logic [AW-1:0] wr_addr, wr_addr_d;
  logic          wr_en;

  logic [DW-1:0] dec_word;
  op_e           dec_op;
  logic          dec_imm;
  logic [AW-1:0] fld_a, fld_b;
  logic [DW-1:0] opnd_a, opnd_b;
  logic [DW-1:0] alu_res;
  logic [AW-1:0] pc_inc;

  // In READ_A the instruction word is still on the read port; afterwards it sits in ir.
  assign dec_word = (state == ST_READ_A) ? mem_rdata : ir;
  assign dec_op   = op_e'(dec_word[OP_LSB +: OPW]);
  assign dec_imm  = dec_word[IMM_BIT];
  assign fld_a    = dec_word[A_LSB +: AW];
  assign fld_b    = dec_word[B_LSB +: AW];
  assign pc_inc   = pc + PC_ONE;

  // The last read issued before EXECUTE is still on mem_rdata.
  assign opnd_a = pend_is_a ? mem_rdata : opa;
  assign opnd_b = (dec_imm && dec_op != OP_CPI) ? {{(DW-AW){1'b0}}, fld_b} : mem_rdata;

  mmc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_op  (dec_op),
    .dec_imm (dec_imm),
    .state   (state)
  );

  mmc_alu #(.DW(DW)) u_alu (
    .op     (dec_op),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (alu_res)
  );

  always_comb begin
    pc_en     = 1'b0;
    pc_d      = pc;
    ir_en     = (state == ST_READ_A);
    opa_en    = (state == ST_READ_B);
    pend_en   = (state == ST_READ_A) || (state == ST_READ_B) || (state == ST_READ_IND);
    res_en    = 1'b0;
    wr_en     = 1'b0;
    wr_addr_d = fld_a;
    if (state == ST_EXECUTE) begin
      if (dec_op == OP_BR) begin
        pc_en = 1'b1;
        if (dec_imm)              pc_d = alu_res[AW-1:0];
        else if (opnd_b == '0)    pc_d = opnd_a[AW-1:0];
        else                      pc_d = pc_inc;
      end else begin
        res_en = 1'b1;
        wr_en  = 1'b1;
        if (dec_op == OP_CPI && dec_imm) wr_addr_d = opnd_a[AW-1:0];
      end
    end else if (state == ST_WRITEBACK) begin
      pc_en = 1'b1;
      pc_d  = pc_inc;
    end
  end

  always_comb begin
    unique case (state)
      ST_FETCH:     mem_addr = pc;
      ST_READ_A:    mem_addr = fld_a;
      ST_READ_B:    mem_addr = fld_b;
      ST_READ_IND:  mem_addr = mem_rdata[AW-1:0];
      ST_WRITEBACK: mem_addr = wr_addr;
      default:      mem_addr = pc;
    endcase
  end

  assign mem_we    = (state == ST_WRITEBACK);
  assign mem_wdata = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      ir        <= '0;
      opa       <= '0;
      pend_is_a <= 1'b0;
      res       <= '0;
      wr_addr   <= '0;
    end else begin
      if (pc_en)   pc        <= pc_d;
      if (ir_en)   ir        <= mem_rdata;
      if (opa_en)  opa       <= mem_rdata;
      if (pend_en) pend_is_a <= (state == ST_READ_A);
      if (res_en)  res       <= alu_res;
      if (wr_en)   wr_addr   <= wr_addr_d;
    end
  end

  AST_PC_HOLD_IN_READS: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FETCH || state == ST_READ_A || state == ST_READ_B || state == ST_READ_IND) |=> $stable(pc)) else $error("pc moved during operand reads"); // R10
  AST_PC_STEP_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_WRITEBACK) |=> (pc == $past(pc) + PC_ONE)) else $error("pc did not advance by one after writeback"); // R10
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we) else $error("write strobe held for two cycles"); // R11
  AST_BR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_EXECUTE && dec_op == OP_BR) |=> (!mem_we && state == ST_FETCH)) else $error("branch produced a memory write"); // R8

endmodule

// File: tb/sim_mmc_core.sv
module sim_mmc_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  function automatic logic [31:0] mk(input int op, input int im, input int a, input int b);
    return {op[2:0], im[0], a[13:0], b[13:0]};
  endfunction

  // {instruction, mem[A], mem[B], expected mem[A]}
  localparam logic [127:0] VEC [NV] = '{
    {mk(0,0,10,20),   32'd5,         32'd7,         32'd12},
    {mk(0,0,10,20),   32'hFFFFFFFF,  32'd2,         32'd1},
    {mk(0,1,10,16383),32'd100,       32'd0,         32'h00004063},
    {mk(1,0,10,20),   32'hF0F0F0F0,  32'hFF00FF00,  32'h0FFF0FFF},
    {mk(1,1,10,255),  32'hFFFFFFFF,  32'd0,         32'hFFFFFF00},
    {mk(2,0,10,20),   32'h80000000,  32'd4,         32'h08000000},
    {mk(2,0,10,20),   32'd1,         32'd35,        32'd8},
    {mk(2,0,10,20),   32'd1,         32'd31,        32'd0},
    {mk(2,0,10,20),   32'd3,         32'd63,        32'h80000000},
    {mk(2,0,10,20),   32'hFFFFFFFF,  32'd64,        32'd0},
    {mk(2,1,10,8),    32'h00000100,  32'd0,         32'd1},
    {mk(2,1,10,32),   32'd1,         32'd0,         32'd1},
    {mk(3,0,10,20),   32'd3,         32'd5,         32'd1},
    {mk(3,0,10,20),   32'd5,         32'd5,         32'd0},
    {mk(3,0,10,20),   32'd1,         32'hFFFFFFFF,  32'd1},
    {mk(3,1,10,30),   32'd20,        32'd0,         32'd1},
    {mk(7,0,10,20),   32'h00010000,  32'h00010001,  32'h00010000},
    {mk(7,1,10,6),    32'd7,         32'd0,         32'd42},
    {mk(4,0,10,20),   32'd9,         32'hDEADBEEF,  32'hDEADBEEF}
  };

  logic        clk;
  logic        rst_n;
  logic [13:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  logic [31:0] mem [int];
  int nwr;
  int nchk;
  int nerr;

  mmc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rd(input int k);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  always @(posedge clk) begin
    int k;
    k = int'(mem_addr);
    mem_rdata <= rd(k);
    if (mem_we) begin
      mem[k] = mem_wdata;
      nwr = nwr + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mem.delete();
    @(negedge clk);
  endtask

  task automatic run(input int len, output int writes);
    int w0;
    @(negedge clk);
    rst_n = 1'b1;
    w0 = nwr;
    repeat (len) @(posedge clk);
    @(negedge clk);
    writes = nwr - w0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int w;
    nwr = 0; nchk = 0; nerr = 0;
    rst_n = 1'b0;

    // R1: reset state
    hold_reset();
    check("R1 addr in reset", {18'd0, mem_addr}, 32'd0);
    check("R1 we in reset", {31'd0, mem_we}, 32'd0);

    // Table of ALU and copy vectors: R2 R3 R4 R5 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [31:0] ins;
      int ea, eb, len;
      string tag;
      ins = VEC[i][127:96];
      ea  = int'(ins[27:14]);
      eb  = int'(ins[13:0]);
      len = ins[28] ? 4 : 5;
      tag = (ins[31:29] == 3'd2) ? "R4" : (ins[31:29] == 3'd4) ? "R5" : "R3";
      hold_reset();
      mem[0]  = ins;
      mem[ea] = VEC[i][95:64];
      if (!ins[28]) mem[eb] = VEC[i][63:32];
      run(len, w);
      check(tag, rd(ea), VEC[i][31:0]);
      check("R10 next pc", {18'd0, mem_addr}, 32'd1);
      check("R11 one write", w, 32'd1);
      if (!ins[28]) check("R2 field B untouched", rd(eb), VEC[i][63:32]);
    end

    // R5: immediate copy
    hold_reset();
    mem[0] = mk(4,1,10,16'h1234); mem[10] = 32'd77;
    run(4, w);
    check("R5 copy immediate", rd(10), 32'h1234);
    check("R11 copy-imm length", {18'd0, mem_addr}, 32'd1);

    // R6: pointer read into A, pointer truncated
    hold_reset();
    mem[0] = mk(5,0,10,20); mem[20] = 32'h0004012C; mem[300] = 32'h0000CAFE;
    run(6, w);
    check("R6 indirect read", rd(10), 32'h0000CAFE);
    check("R11 indirect read length", {18'd0, mem_addr}, 32'd1);

    // R7: store through pointer held in A, truncated
    hold_reset();
    mem[0] = mk(5,1,10,20); mem[10] = 32'h00010190; mem[20] = 32'h0000BEEF;
    run(5, w);
    check("R7 indirect store", rd(400), 32'h0000BEEF);
    check("R7 pointer unchanged", rd(10), 32'h00010190);
    check("R11 indirect store writes", w, 32'd1);

    // R8: branch taken
    hold_reset();
    mem[0] = mk(6,0,10,20); mem[10] = 32'h55; mem[20] = 32'd0;
    run(4, w);
    check("R8 taken pc", {18'd0, mem_addr}, 32'h55);
    check("R8 no write", w, 32'd0);

    // R8: branch not taken
    hold_reset();
    mem[0] = mk(6,0,10,20); mem[10] = 32'h55; mem[20] = 32'd1;
    run(4, w);
    check("R8 not-taken pc", {18'd0, mem_addr}, 32'd1);

    // R8: target truncated to 14 bits
    hold_reset();
    mem[0] = mk(6,0,10,20); mem[10] = 32'h00012345; mem[20] = 32'd0;
    run(4, w);
    check("R8 truncated target", {18'd0, mem_addr}, 32'h2345);

    // R9: jump with wrap
    hold_reset();
    mem[0] = mk(6,1,10,5); mem[10] = 32'h3FFE;
    run(3, w);
    check("R9 jump target", {18'd0, mem_addr}, 32'd3);
    check("R9 no write", w, 32'd0);

    // R10: pc wraps from last word to 0
    hold_reset();
    mem[0] = mk(6,1,10,0); mem[10] = 32'h3FFF;
    mem[16383] = mk(0,1,11,1); mem[11] = 32'd9;
    run(7, w);
    check("R10 pc wrap", {18'd0, mem_addr}, 32'd0);
    check("R10 wrapped instruction result", rd(11), 32'd10);

    // R1: reset mid-instruction aborts without writing
    hold_reset();
    mem[0] = mk(0,0,10,20); mem[10] = 32'd5; mem[20] = 32'd7;
    run(2, w);
    rst_n = 1'b0;
    #1;
    check("R1 addr after mid reset", {18'd0, mem_addr}, 32'd0);
    check("R1 we after mid reset", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    check("R1 no write after abort", rd(10), 32'd5);

    finish_up();
  end

endmodule